// File: doc/BRIEF.md
# Selectable Saturating Event Counters

This block is a small performance monitor that hangs off an APB slave port. It watches a 20-bit vector of single-cycle event pulses coming from a bus crossbar and keeps four independent 24-bit counters. Each of the ten downstream crossbar ports supplies two pulses: one for a contested access and one for any access. A contested access is one that competed with another master for the same downstream port.

Software gives each counter a 5-bit event code through its own select register and reads the count back over APB. A counter never wraps: it stops at its all-ones value. Any write to a counter register zeroes it. After reset every select holds an out-of-range code, so nothing is counted until software picks an event.

The bus side has no wait states and never signals an error. Producing the event pulses inside the crossbar is outside this block.

Top module: `evt_mon`

## Requirements
- R1: After a synchronous reset every counter reads 0 and every select register reads 0x1F.
- R2: Counter k (k = 0..3) is read and cleared at byte offset 0x08 + 8k, and its select register is written and read back at offset 0x0C + 8k, with the code in bits [4:0].
- R3: A counter that reaches 2^CTR_W - 1 (0xFFFFFF by default) holds that value on further events instead of wrapping.
- R4: A write of any data to a counter offset sets it to 0, and if its selected event fires in the same cycle as the clearing write, the counter still reads 0 afterwards.
- R5: Event code c in 0x00..0x13 counts `evt_i[c]`. Ports take code pairs in this order: APB 0x00/0x01, fast peripheral 0x02/0x03, SRAM5 0x04/0x05, SRAM4 0x06/0x07, SRAM3 0x08/0x09, SRAM2 0x0A/0x0B, SRAM1 0x0C/0x0D, SRAM0 0x0E/0x0F, XIP 0x10/0x11, ROM 0x12/0x13. The even code of each pair is the contested-access pulse and the odd code is the any-access pulse.
- R6: While a select register holds a code from 0x14 to 0x1F, its counter does not change, whatever the event inputs do.
- R7: A counter rises by exactly one on each clock edge at which its selected event is high, and by at most one per clock.
- R8: Bits above a register's width read as 0, offsets that map to no register read as 0, and writes to them change nothing. `pready` is always 1 and `pslverr` is always 0.
- R9: The four counters count independently, each following its own select code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when 1, read when 0 |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error, always 0 |
| evt_i | input | 20 | Single-cycle event pulses, bit c answers to code c |

## Verification
The bench goes after the corners where a wrong design looks plausible. It drives an event in the same cycle as a clearing write, where an add that wins over the clear leaves 1 instead of 0. It pushes a reduced-width instance past its ceiling, where a wrapping counter falls back to a small value. It checks the idle codes 0x14 and 0x1F with every event line high, where an unguarded index would pick up a neighbouring pulse or an X. Swapped contested and any-access codes, and a counter that reads its event level once instead of once per cycle, both show up as wrong counts in the table of select and pulse patterns.

// File: rtl/evt_mon_pkg.sv
package evt_mon_pkg;

    // event and select geometry
    localparam int EVT_PORTS  = 10;
    localparam int NUM_EVT    = 2 * EVT_PORTS;
    localparam int SEL_W      = 5;
    localparam logic [SEL_W-1:0] SEL_IDLE = 5'h1F;

    // register layout: counter at base + stride*k, select just above it
    localparam int CTR_BASE   = 8;
    localparam int REG_STRIDE = 8;
    localparam int SEL_OFS    = 4;

    // downstream ports in code order
    typedef enum logic [3:0] {
        PORT_APB, PORT_FASTPERI, PORT_SRAM5, PORT_SRAM4, PORT_SRAM3,
        PORT_SRAM2, PORT_SRAM1, PORT_SRAM0, PORT_XIP, PORT_ROM
    } port_e;

    // kind of register an access lands on
    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_CTR,
        ACC_SEL
    } acc_e;

    // decoded bus access
    typedef struct packed {
        acc_e       kind;
        logic [7:0] idx;
    } acc_t;

    // code for a port: even = contested, odd = any access
    function automatic logic [SEL_W-1:0] evt_code(port_e p, logic contested);
        return {p, ~contested};
    endfunction

    function automatic int ctr_offset(int k);
        return CTR_BASE + k * REG_STRIDE;
    endfunction

    function automatic int sel_offset(int k);
        return CTR_BASE + k * REG_STRIDE + SEL_OFS;
    endfunction

endpackage

// File: rtl/evt_mon_ctr.sv
module evt_mon_ctr
    import evt_mon_pkg::*;
#(
    parameter int CTR_W   = 24,
    parameter int NUM_EVT = evt_mon_pkg::NUM_EVT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    input  logic [NUM_EVT-1:0] evt,
    output logic [CTR_W-1:0] cnt
);

    localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};

    logic hit;

    // pick the selected pulse; out-of-range codes match nothing
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (sel == SEL_W'(i)) hit = evt[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (hit && (cnt != CTR_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0)); // R4

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        ((cnt == CTR_MAX) && !clr) |=> (cnt == CTR_MAX)); // R3

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + CTR_W'(1)))); // R7

    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst)
        ((sel >= SEL_W'(NUM_EVT)) && !clr) |=> $stable(cnt)); // R6

endmodule

// File: rtl/evt_mon_regif.sv
module evt_mon_regif
    import evt_mon_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 24,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          psel,
    input  logic                          penable,
    input  logic                          pwrite,
    input  logic [ADDR_W-1:0]             paddr,
    input  logic [DATA_W-1:0]             pwdata,
    input  logic [NUM_CTR-1:0][CTR_W-1:0] cnt_all,
    output logic [DATA_W-1:0]             prdata,
    output logic [NUM_CTR-1:0][SEL_W-1:0] sel_all,
    output logic [NUM_CTR-1:0]            clr_vec
);

    localparam int SPAN_END = CTR_BASE + NUM_CTR * REG_STRIDE;
    localparam int IDX_W    = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;

    logic              wr_en;
    logic [ADDR_W-1:0] off;
    acc_t              acc;
    logic [IDX_W-1:0]  idx;
    logic              unused_wdata;

    assign unused_wdata = ^pwdata[DATA_W-1:SEL_W];
    assign wr_en = psel && penable && pwrite;
    assign off   = paddr - ADDR_W'(CTR_BASE);
    assign idx   = IDX_W'(off >> 3);

    // address decode
    always_comb begin
        acc.kind = ACC_NONE;
        acc.idx  = 8'(idx);
        if ((paddr >= ADDR_W'(CTR_BASE)) && (paddr < ADDR_W'(SPAN_END)) &&
            (paddr[1:0] == 2'b00)) begin
            acc.kind = off[2] ? ACC_SEL : ACC_CTR;
        end
    end

    // select registers and clear strobes
    for (genvar k = 0; k < NUM_CTR; k++) begin : g_reg
        logic hit_k;
        assign hit_k      = wr_en && (idx == IDX_W'(k));
        assign clr_vec[k] = hit_k && (acc.kind == ACC_CTR);

        always_ff @(posedge clk) begin
            if (rst) begin
                sel_all[k] <= SEL_IDLE;
            end else if (hit_k && (acc.kind == ACC_SEL)) begin
                sel_all[k] <= pwdata[SEL_W-1:0];
            end
        end

        AST_SEL_LOAD: assert property (@(posedge clk) disable iff (rst)
            (wr_en && (paddr == ADDR_W'(sel_offset(k))))
            |=> (sel_all[k] == $past(pwdata[SEL_W-1:0]))); // R2
    end

    // read mux, zero-extended
    always_comb begin
        prdata = '0;
        case (acc.kind)
            ACC_CTR: prdata = DATA_W'(cnt_all[idx]);
            ACC_SEL: prdata = DATA_W'(sel_all[idx]);
            default: prdata = '0;
        endcase
    end

endmodule

// File: rtl/evt_mon.sv
module evt_mon
    import evt_mon_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 24,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      psel,
    input  logic                      penable,
    input  logic                      pwrite,
    input  logic [ADDR_W-1:0]         paddr,
    input  logic [DATA_W-1:0]         pwdata,
    output logic [DATA_W-1:0]         prdata,
    output logic                      pready,
    output logic                      pslverr,
    input  logic [NUM_EVT-1:0]        evt_i
);

    logic [NUM_CTR-1:0][CTR_W-1:0] cnt_all;
    logic [NUM_CTR-1:0][SEL_W-1:0] sel_all;
    logic [NUM_CTR-1:0]            clr_vec;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    evt_mon_regif #(
        .NUM_CTR (NUM_CTR),
        .CTR_W   (CTR_W),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) regif_i (
        .clk     (clk),
        .rst     (rst),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .cnt_all (cnt_all),
        .prdata  (prdata),
        .sel_all (sel_all),
        .clr_vec (clr_vec)
    );

    for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
        evt_mon_ctr #(
            .CTR_W   (CTR_W),
            .NUM_EVT (NUM_EVT)
        ) ctr_i (
            .clk (clk),
            .rst (rst),
            .clr (clr_vec[k]),
            .sel (sel_all[k]),
            .evt (evt_i),
            .cnt (cnt_all[k])
        );
    end

endmodule

// File: tb/evt_mon_tb.sv
module evt_mon_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SAT_W      = 6;
    localparam int NVEC       = 8;

    // {select code, event pattern, cycles held, expected count}
    localparam logic [56:0] VEC [NVEC] = '{
        {5'h01, 20'h00002, 8'd5, 24'd5},   // APB any access
        {5'h00, 20'h00002, 8'd5, 24'd0},   // APB contested, only any-access pulse
        {5'h13, 20'h80000, 8'd7, 24'd7},   // ROM any access
        {5'h12, 20'hC0000, 8'd3, 24'd3},   // ROM contested
        {5'h0A, 20'hFFFFF, 8'd4, 24'd4},   // SRAM2 contested, all lines high
        {5'h14, 20'hFFFFF, 8'd6, 24'd0},   // idle code
        {5'h1F, 20'hFFFFF, 8'd2, 24'd0},   // idle code
        {5'h09, 20'h00100, 8'd5, 24'd0}    // SRAM3 any, neighbour pulse only
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata, prdata_s;
    logic        pready, pslverr, pready_s, pslverr_s;
    logic [19:0] evt_i = '0;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_mon dut_i (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .evt_i(evt_i)
    );

    evt_mon #(.CTR_W(SAT_W)) sat_i (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata_s), .pready(pready_s),
        .pslverr(pslverr_s), .evt_i(evt_i)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic [31:0] ds);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1;
        d  = prdata;
        ds = prdata_s;
        check("R8 pready high", {31'd0, pready}, 32'd1);
        check("R8 pslverr low", {31'd0, pslverr}, 32'd0);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic pulse(input logic [19:0] v, input int n);
        @(negedge clk);
        evt_i = v;
        repeat (n - 1) @(negedge clk);
        #1;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic done();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=timeout exp=completion");
        done();
    end

    initial begin
        logic [31:0] d, ds;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        for (int k = 0; k < 4; k++) begin
            rd(12'(8 + 8*k), d, ds);
            check("R1 counter reset", d, 32'd0);
            rd(12'(12 + 8*k), d, ds);
            check("R1 select reset", d, 32'h1F);
        end

        // R5 R6 R7 table of codes and patterns on counter 0
        for (int i = 0; i < NVEC; i++) begin
            wr(12'h008, 32'h0);
            wr(12'h00C, {27'd0, VEC[i][56:52]});
            pulse(VEC[i][51:32], int'(VEC[i][31:24]));
            rd(12'h008, d, ds);
            check($sformatf("R5/R6 vector %0d", i), d, {8'd0, VEC[i][23:0]});
        end

        // R7 alternating pulses count once per high cycle
        wr(12'h008, 32'h0);
        wr(12'h00C, 32'h1);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            evt_i = (i % 2 == 0) ? 20'h00002 : 20'h0;
        end
        @(negedge clk);
        evt_i = '0;
        rd(12'h008, d, ds);
        check("R7 alternating pulses", d, 32'd5);

        // R4 clear with any data, event during the clearing write
        evt_i = 20'h00002;
        wr(12'h008, 32'hDEADBEEF);
        evt_i = '0;
        rd(12'h008, d, ds);
        check("R4 clear wins over event", d, 32'd0);

        // R2 R8 select read-back trims upper bits; unmapped offsets
        wr(12'h014, 32'hFFFFFFE3);
        rd(12'h014, d, ds);
        check("R2 select read back", d, 32'h03);
        wr(12'h028, 32'h1);
        rd(12'h028, d, ds);
        check("R8 unmapped reads zero", d, 32'd0);
        rd(12'h000, d, ds);
        check("R8 offset 0 reads zero", d, 32'd0);
        rd(12'h00D, d, ds);
        check("R8 unaligned reads zero", d, 32'd0);

        // R9 independent counters, each with its own code
        wr(12'h00C, 32'h01);
        wr(12'h014, 32'h03);
        wr(12'h01C, 32'h0F);
        wr(12'h024, 32'h14);
        for (int k = 0; k < 4; k++) wr(12'(8 + 8*k), 32'h0);
        pulse(20'h0800A, 4);
        pulse(20'h00002, 3);
        rd(12'h008, d, ds);
        check("R9 counter0", d, 32'd7);
        rd(12'h010, d, ds);
        check("R9 counter1", d, 32'd4);
        rd(12'h018, d, ds);
        check("R9 counter2", d, 32'd4);
        rd(12'h020, d, ds);
        check("R9 counter3 idle code", d, 32'd0);

        // R3 saturation on the narrow instance, default keeps counting
        wr(12'h008, 32'h0);
        pulse(20'h00002, 70);
        rd(12'h008, d, ds);
        check("R3 narrow counter saturates", ds, 32'd63);
        check("R3 wide counter still counting", d, 32'd70);
        pulse(20'h00002, 5);
        rd(12'h008, d, ds);
        check("R3 narrow counter holds", ds, 32'd63);
        wr(12'h008, 32'h0);
        rd(12'h008, d, ds);
        check("R4 clear from saturation", ds, 32'd0);

        // R1 reset again restores selects
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(12'h014, d, ds);
        check("R1 select after reset", d, 32'h1F);

        done();
    end

endmodule